// File: doc/BRIEF.md
# Upgrade-Tracking Miss Entry

This block is one miss-status entry for a cache, together with the address matching and response-side control around it. The entry is loaded when the cache sends out a request. Most of the time that request is an upgrade: the cache already holds the block read-only and is asking for write permission. While the upgrade is in flight, the replacement logic may choose that very block as a victim. The entry watches victim notices, recognises its own block by comparing the whole block address (tag and set together), and remembers what the evicted copy looked like.

When the upgrade response then arrives and the cache reports that the block is gone, the entry decides what to do before any fill takes place. If the evicted copy was clean, the entry kept a full copy of its data. It turns the upgrade response into an exclusive-read response that carries this saved data, so the normal fill path can install the block as owned. If the evicted copy was dirty, its normal writeback went ahead and no data was kept. In that case the response is dropped, the entry stays pending, and it asks for a fresh exclusive read. Responses of any other kind, and upgrade responses that find the block still present, pass through to the fill path unchanged.

Each event gives at most one outcome one clock later: a fill, a reissue or an error code. The tag array, the replacement policy, the writeback buffer and bus arbitration live elsewhere.

Top module: `mshr_upg_track`

## Requirements
- R1: After reset no output strobe is active. An allocation arms the entry with the given block address and exclusive flag. It also clears any replaced-during-upgrade record and invalidates the saved data, so a later upgrade response with the block absent reports error code 3.
- R2: A victim notice matches the entry only when the entry is armed and {victim tag, victim set} equals the entry's block address. A victim notice that does not match changes nothing and produces no output.
- R3: A matching victim notice that is writable, or that arrives while the entry's request is not exclusive, raises error code 1 (err_code encoding: 0 none, 1 protocol, 2 address, 3 no-record) and leaves the entry's record unchanged.
- R4: After a matching dirty victim, an upgrade response (rsp_kind 2) with the block absent gives a reissue strobe carrying the entry's block address and no fill. The entry stays armed, and a later exclusive-read response (rsp_kind 1) for the block is filled with that response's data.
- R5: After a matching clean victim, an upgrade response with the block absent gives a fill of kind 1 (exclusive read) carrying the victim data saved at notice time, at the entry's block address.
- R6: Handling an upgrade response with the block absent always clears the replaced-during-upgrade record. A second such response then reports error code 3.
- R7: A response whose block address does not match an armed entry, or that arrives while no entry is armed, gives error code 2 and no fill.
- R8: A response of kind 0 (read) or kind 1, or a kind-2 response with the block still present, gives a fill with the response's own kind, data and block address.
- R9: An upgrade response with the block absent and no replaced-during-upgrade record gives error code 3 and no fill.
- R10: Events in the same cycle are resolved with allocation first, then the response, then the victim notice. An event that loses is ignored completely.
- R11: Every outcome is a single-cycle strobe on the clock edge after its event, and at most one of fill, reissue and error is active in any cycle.
- R12: A fill releases the entry, so a following response for the same block gives error code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_vld | input | 1 | Allocate the entry |
| alloc_blk | input | BLK_W | Block address of the new request |
| alloc_excl | input | 1 | Request needs exclusive ownership |
| vic_vld | input | 1 | Victim notice strobe |
| vic_tag | input | TAG_W | Tag of the victim block |
| vic_set | input | SET_W | Set index of the victim block |
| vic_dirty | input | 1 | Victim holds modified data |
| vic_writable | input | 1 | Victim held write permission |
| vic_data | input | DATA_W | Victim block data |
| rsp_vld | input | 1 | Response strobe |
| rsp_kind | input | 2 | 0 read, 1 exclusive read, 2 upgrade |
| rsp_blk | input | BLK_W | Block address of the response |
| rsp_blk_present | input | 1 | Block still present in the cache |
| rsp_data | input | DATA_W | Response data |
| fill_vld | output | 1 | Fill strobe |
| fill_kind | output | 2 | Kind of the fill response |
| fill_blk | output | BLK_W | Block address of the fill |
| fill_data | output | DATA_W | Fill data |
| reissue_vld | output | 1 | Exclusive read must be reissued |
| reissue_blk | output | BLK_W | Block address to reissue |
| err_vld | output | 1 | Error strobe |
| err_code | output | 2 | Error code |

## Verification
The bench drives victim notices of every kind against an armed entry: a non-matching address, a clean block, a dirty block, a writable block, and a block under a non-exclusive request. Each notice is followed by an upgrade response with the block absent. The outcome of that response (converted fill, reissue, protocol error or no-record error) shows which record the notice left behind. Read, exclusive-read and block-present upgrade responses check that the pass-through path does not disturb the response. Repeated responses after a reissue and after a fill separate clearing the record from freeing the entry. Same-cycle event pairs check the priority order.

// File: rtl/mshr_upg_pkg.sv
package mshr_upg_pkg;

   typedef enum logic [1:0] {
      RSP_READ    = 2'd0,
      RSP_READEX  = 2'd1,
      RSP_UPGRADE = 2'd2,
      RSP_RSVD    = 2'd3
   } rsp_kind_e;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_PROTO  = 2'd1,
      ERR_ADDR   = 2'd2,
      ERR_NOREC  = 2'd3
   } err_code_e;

   typedef enum logic [1:0] {
      EV_IDLE  = 2'd0,
      EV_ALLOC = 2'd1,
      EV_RSP   = 2'd2,
      EV_VIC   = 2'd3
   } event_e;

endpackage

// File: rtl/mshr_blk_cmp.sv
// Block-address equality, split into chunks so the reduction depth follows CHUNK_W.
module mshr_blk_cmp #(
   parameter int W       = 26,
   parameter int CHUNK_W = 8
) (
   input  logic         en,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         hit
);
   localparam int NCHUNK = (W + CHUNK_W - 1) / CHUNK_W;
   localparam int PAD_W  = NCHUNK * CHUNK_W;

   generate
      if (W < 1 || CHUNK_W < 1) begin : g_bad_width
         $error("mshr_blk_cmp: widths must be positive");
      end

      if (CHUNK_W >= W) begin : g_flat
         assign hit = en && (a == b);
      end else begin : g_chunked
         logic [PAD_W-1:0]  a_pad;
         logic [PAD_W-1:0]  b_pad;
         logic [NCHUNK-1:0] eq;
         assign a_pad = PAD_W'(a);
         assign b_pad = PAD_W'(b);
         for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
            assign eq[c] = (a_pad[c*CHUNK_W +: CHUNK_W] == b_pad[c*CHUNK_W +: CHUNK_W]);
         end
         assign hit = en && (&eq);
      end
   endgenerate
endmodule

// File: rtl/mshr_vic_buf.sv
// One-block holding buffer for a clean victim, organised as write-together lanes.
module mshr_vic_buf #(
   parameter int DATA_W       = 128,
   parameter int LANE_W       = 32,
   parameter bit CLEAR_ON_REL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rel,
   output logic [DATA_W-1:0] rd_data,
   output logic              held
);
   localparam int NLANE = DATA_W / LANE_W;

   generate
      if (LANE_W < 1 || DATA_W < LANE_W || (DATA_W % LANE_W) != 0) begin : g_bad_lane
         $error("mshr_vic_buf: DATA_W must be a whole multiple of LANE_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
      end else if (wr_en) begin
         held <= 1'b1;
      end else if (rel) begin
         held <= 1'b0;
      end
   end

   generate
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         logic [LANE_W-1:0] lane_q;
         if (CLEAR_ON_REL) begin : g_scrub
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lane_q <= '0;
               end else if (wr_en) begin
                  lane_q <= wr_data[l*LANE_W +: LANE_W];
               end else if (rel) begin
                  lane_q <= '0;
               end
            end
         end else begin : g_keep
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lane_q <= '0;
               end else if (wr_en) begin
                  lane_q <= wr_data[l*LANE_W +: LANE_W];
               end
            end
         end
         assign rd_data[l*LANE_W +: LANE_W] = lane_q;
      end
   endgenerate
endmodule

// File: rtl/mshr_upg_ctl.sv
// Entry state and event resolution: allocation, response handling, victim record.
module mshr_upg_ctl
   import mshr_upg_pkg::*;
#(
   parameter int BLK_W  = 26,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_vld,
   input  logic [BLK_W-1:0]  alloc_blk,
   input  logic              alloc_excl,
   input  logic              vic_vld,
   input  logic              vic_hit,
   input  logic              vic_dirty,
   input  logic              vic_writable,
   input  logic              rsp_vld,
   input  logic              rsp_hit,
   input  logic [1:0]        rsp_kind,
   input  logic              rsp_present,
   input  logic [BLK_W-1:0]  rsp_blk,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [DATA_W-1:0] buf_data,
   input  logic              buf_held,
   output logic              ent_valid,
   output logic [BLK_W-1:0]  ent_blk,
   output logic              buf_wr,
   output logic              buf_rel,
   output logic              fill_vld,
   output logic [1:0]        fill_kind,
   output logic [BLK_W-1:0]  fill_blk,
   output logic [DATA_W-1:0] fill_data,
   output logic              reissue_vld,
   output logic [BLK_W-1:0]  reissue_blk,
   output logic              err_vld,
   output logic [1:0]        err_code
);
   // entry state
   logic             valid_q, valid_d;
   logic [BLK_W-1:0] blk_q, blk_d;
   logic             excl_q, excl_d;
   logic             repl_q, repl_d;
   logic             dirty_q, dirty_d;

   // outcome of this cycle
   logic              fill_d;
   rsp_kind_e         fkind_d;
   logic [DATA_W-1:0] fdata_d;
   logic              reiss_d;
   err_code_e         ecode_d;
   event_e            ev;
   logic              upg_absent;

   // priority: allocation, then response, then victim notice
   always_comb begin
      if (alloc_vld)       ev = EV_ALLOC;
      else if (rsp_vld)    ev = EV_RSP;
      else if (vic_vld)    ev = EV_VIC;
      else                 ev = EV_IDLE;
   end

   assign upg_absent = (rsp_kind_e'(rsp_kind) == RSP_UPGRADE) && !rsp_present;

   always_comb begin
      valid_d = valid_q;
      blk_d   = blk_q;
      excl_d  = excl_q;
      repl_d  = repl_q;
      dirty_d = dirty_q;
      buf_wr  = 1'b0;
      buf_rel = 1'b0;
      fill_d  = 1'b0;
      fkind_d = RSP_READ;
      fdata_d = rsp_data;
      reiss_d = 1'b0;
      ecode_d = ERR_NONE;

      unique case (ev)
         EV_ALLOC: begin
            valid_d = 1'b1;
            blk_d   = alloc_blk;
            excl_d  = alloc_excl;
            repl_d  = 1'b0;
            dirty_d = 1'b0;
            buf_rel = 1'b1;
         end
         EV_RSP: begin
            if (!rsp_hit) begin
               ecode_d = ERR_ADDR;
            end else if (upg_absent) begin
               if (!repl_q) begin
                  ecode_d = ERR_NOREC;
               end else begin
                  repl_d = 1'b0;
                  if (dirty_q) begin
                     // copy was written back: ask again for the whole block
                     reiss_d = 1'b1;
                     dirty_d = 1'b0;
                  end else if (!buf_held) begin
                     ecode_d = ERR_NOREC;
                  end else begin
                     // saved clean copy becomes the owned data
                     fill_d  = 1'b1;
                     fkind_d = RSP_READEX;
                     fdata_d = buf_data;
                     buf_rel = 1'b1;
                     valid_d = 1'b0;
                  end
               end
            end else begin
               fill_d  = 1'b1;
               fkind_d = rsp_kind_e'(rsp_kind);
               fdata_d = rsp_data;
               repl_d  = 1'b0;
               dirty_d = 1'b0;
               buf_rel = 1'b1;
               valid_d = 1'b0;
            end
         end
         EV_VIC: begin
            if (vic_hit) begin
               if (vic_writable || !excl_q) begin
                  ecode_d = ERR_PROTO;
               end else begin
                  repl_d  = 1'b1;
                  dirty_d = vic_dirty;
                  buf_wr  = !vic_dirty;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         blk_q   <= '0;
         excl_q  <= 1'b0;
         repl_q  <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         valid_q <= valid_d;
         blk_q   <= blk_d;
         excl_q  <= excl_d;
         repl_q  <= repl_d;
         dirty_q <= dirty_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_vld    <= 1'b0;
         fill_kind   <= 2'd0;
         fill_blk    <= '0;
         fill_data   <= '0;
         reissue_vld <= 1'b0;
         reissue_blk <= '0;
         err_vld     <= 1'b0;
         err_code    <= 2'd0;
      end else begin
         fill_vld    <= fill_d;
         reissue_vld <= reiss_d;
         err_vld     <= (ecode_d != ERR_NONE);
         err_code    <= ecode_d;
         if (fill_d) begin
            fill_kind <= fkind_d;
            fill_blk  <= blk_q;
            fill_data <= fdata_d;
         end
         if (reiss_d) begin
            reissue_blk <= blk_q;
         end
      end
   end

   assign ent_valid = valid_q;
   assign ent_blk   = blk_q;

   // rsp_blk reaches the controller only through rsp_hit; kept for the trace of the port set
   logic unused_rsp_blk;
   assign unused_rsp_blk = ^rsp_blk;
endmodule

// File: rtl/mshr_upg_track.sv
module mshr_upg_track #(
   parameter int ADDR_W       = 32,
   parameter int SET_W        = 6,
   parameter int OFFS_W       = 6,
   parameter int DATA_W       = 128,
   parameter int LANE_W       = 32,
   parameter int CMP_CHUNK_W  = 8,
   parameter bit CLEAR_ON_REL = 1'b1,
   localparam int BLK_W       = ADDR_W - OFFS_W,
   localparam int TAG_W       = ADDR_W - SET_W - OFFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_vld,
   input  logic [BLK_W-1:0]  alloc_blk,
   input  logic              alloc_excl,
   input  logic              vic_vld,
   input  logic [TAG_W-1:0]  vic_tag,
   input  logic [SET_W-1:0]  vic_set,
   input  logic              vic_dirty,
   input  logic              vic_writable,
   input  logic [DATA_W-1:0] vic_data,
   input  logic              rsp_vld,
   input  logic [1:0]        rsp_kind,
   input  logic [BLK_W-1:0]  rsp_blk,
   input  logic              rsp_blk_present,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              fill_vld,
   output logic [1:0]        fill_kind,
   output logic [BLK_W-1:0]  fill_blk,
   output logic [DATA_W-1:0] fill_data,
   output logic              reissue_vld,
   output logic [BLK_W-1:0]  reissue_blk,
   output logic              err_vld,
   output logic [1:0]        err_code
);
   generate
      if (TAG_W < 1) begin : g_bad_split
         $error("mshr_upg_track: set and offset bits leave no tag");
      end
   endgenerate

   logic              ent_valid;
   logic [BLK_W-1:0]  ent_blk;
   logic [BLK_W-1:0]  vic_blk;
   logic              vic_hit;
   logic              rsp_hit;
   logic              buf_wr;
   logic              buf_rel;
   logic              buf_held;
   logic [DATA_W-1:0] buf_data;

   // rebuild the victim's block address from its tag and set
   assign vic_blk = {vic_tag, vic_set};

   mshr_blk_cmp #(.W(BLK_W), .CHUNK_W(CMP_CHUNK_W)) u_vic_cmp (
      .en (ent_valid),
      .a  (vic_blk),
      .b  (ent_blk),
      .hit(vic_hit)
   );

   mshr_blk_cmp #(.W(BLK_W), .CHUNK_W(CMP_CHUNK_W)) u_rsp_cmp (
      .en (ent_valid),
      .a  (rsp_blk),
      .b  (ent_blk),
      .hit(rsp_hit)
   );

   mshr_vic_buf #(.DATA_W(DATA_W), .LANE_W(LANE_W), .CLEAR_ON_REL(CLEAR_ON_REL)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (buf_wr),
      .wr_data(vic_data),
      .rel    (buf_rel),
      .rd_data(buf_data),
      .held   (buf_held)
   );

   mshr_upg_ctl #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_vld   (alloc_vld),
      .alloc_blk   (alloc_blk),
      .alloc_excl  (alloc_excl),
      .vic_vld     (vic_vld),
      .vic_hit     (vic_hit),
      .vic_dirty   (vic_dirty),
      .vic_writable(vic_writable),
      .rsp_vld     (rsp_vld),
      .rsp_hit     (rsp_hit),
      .rsp_kind    (rsp_kind),
      .rsp_present (rsp_blk_present),
      .rsp_blk     (rsp_blk),
      .rsp_data    (rsp_data),
      .buf_data    (buf_data),
      .buf_held    (buf_held),
      .ent_valid   (ent_valid),
      .ent_blk     (ent_blk),
      .buf_wr      (buf_wr),
      .buf_rel     (buf_rel),
      .fill_vld    (fill_vld),
      .fill_kind   (fill_kind),
      .fill_blk    (fill_blk),
      .fill_data   (fill_data),
      .reissue_vld (reissue_vld),
      .reissue_blk (reissue_blk),
      .err_vld     (err_vld),
      .err_code    (err_code)
   );
endmodule

// File: rtl/mshr_upg_track_chk.sv
module mshr_upg_track_chk #(
   parameter int BLK_W = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_vld,
   input logic             vic_vld,
   input logic             rsp_vld,
   input logic [1:0]       rsp_kind,
   input logic [BLK_W-1:0] rsp_blk,
   input logic             rsp_blk_present,
   input logic             fill_vld,
   input logic [1:0]       fill_kind,
   input logic             reissue_vld,
   input logic [BLK_W-1:0] reissue_blk,
   input logic             err_vld,
   input logic [1:0]       err_code
);
   a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fill_vld, reissue_vld, err_vld}));

   a_r10_alloc_silent: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vld |=> (!fill_vld && !reissue_vld && !err_vld));

   a_r11_no_rsp_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |=> (!fill_vld && !reissue_vld));

   a_r4_reissue_cause: assert property (@(posedge clk) disable iff (!rst_n)
      reissue_vld |-> $past(rsp_vld && !alloc_vld && rsp_kind == 2'd2 && !rsp_blk_present));

   a_r4_reissue_block: assert property (@(posedge clk) disable iff (!rst_n)
      reissue_vld |-> (reissue_blk == $past(rsp_blk)));

   a_r5_converted_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_vld && $past(rsp_kind == 2'd2 && !rsp_blk_present)) |-> (fill_kind == 2'd1));

   a_r3_proto_from_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && err_code == 2'd1) |-> $past(vic_vld && !rsp_vld && !alloc_vld));

   a_r7_code_present: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |-> (err_code != 2'd0));
endmodule

bind mshr_upg_track mshr_upg_track_chk #(.BLK_W(BLK_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alloc_vld      (alloc_vld),
   .vic_vld        (vic_vld),
   .rsp_vld        (rsp_vld),
   .rsp_kind       (rsp_kind),
   .rsp_blk        (rsp_blk),
   .rsp_blk_present(rsp_blk_present),
   .fill_vld       (fill_vld),
   .fill_kind      (fill_kind),
   .reissue_vld    (reissue_vld),
   .reissue_blk    (reissue_blk),
   .err_vld        (err_vld),
   .err_code       (err_code)
);

// File: tb/mshr_upg_track_test.sv
`timescale 1ns/1ps
module mshr_upg_track_test;
   localparam int ADDR_W = 32;
   localparam int SET_W  = 6;
   localparam int OFFS_W = 6;
   localparam int DATA_W = 128;
   localparam int BLK_W  = ADDR_W - OFFS_W;
   localparam int TAG_W  = ADDR_W - SET_W - OFFS_W;

   localparam logic [31:0] AA = 32'h0000_1240;
   localparam logic [31:0] BB = 32'h0000_8880;

   // op: 0 allocate, 1 victim, 2 response
   // f1: alloc exclusive / victim dirty / response block present; f2: victim writable
   // eout: 0 nothing, 1 fill, 2 reissue, 3 error; ecode: fill kind or error code
   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] addr;
      logic        f1;
      logic        f2;
      logic [1:0]  kind;
      logic [15:0] seed;
      logic [1:0]  eout;
      logic [1:0]  ecode;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 22;
   localparam vec_t VECS [0:NVEC-1] = '{
      '{2'd0, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd1},  // R1 arm
      '{2'd1, BB, 1'b0, 1'b0, 2'd0, 16'hBEEF, 2'd0, 2'd0, 4'd2},  // R2 foreign victim
      '{2'd2, AA, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd3, 2'd3, 4'd9},  // R9 no record
      '{2'd1, AA, 1'b0, 1'b0, 2'd0, 16'hA5C3, 2'd0, 2'd0, 4'd5},  // R5 clean victim
      '{2'd2, AA, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd1, 2'd1, 4'd5},  // R5 converted
      '{2'd2, AA, 1'b1, 1'b0, 2'd0, 16'h1234, 2'd3, 2'd2, 4'd12}, // R12 freed
      '{2'd0, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd1},
      '{2'd1, AA, 1'b1, 1'b0, 2'd0, 16'h1111, 2'd0, 2'd0, 4'd4},  // R4 dirty victim
      '{2'd2, AA, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd2, 2'd0, 4'd4},  // R4 reissue
      '{2'd2, AA, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd3, 2'd3, 4'd6},  // R6 record cleared
      '{2'd2, AA, 1'b0, 1'b0, 2'd1, 16'h7E01, 2'd1, 2'd1, 4'd4},  // R4 exclusive data
      '{2'd0, BB, 1'b0, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd1},
      '{2'd1, BB, 1'b0, 1'b0, 2'd0, 16'h4444, 2'd3, 2'd1, 4'd3},  // R3 not exclusive
      '{2'd2, BB, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd3, 2'd3, 4'd3},  // R3 record unchanged
      '{2'd2, BB, 1'b1, 1'b0, 2'd0, 16'h5A5A, 2'd1, 2'd0, 4'd8},  // R8 read passes
      '{2'd0, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd1},
      '{2'd1, AA, 1'b0, 1'b1, 2'd0, 16'h6666, 2'd3, 2'd1, 4'd3},  // R3 writable victim
      '{2'd1, AA, 1'b0, 1'b0, 2'd0, 16'h3C3C, 2'd0, 2'd0, 4'd5},
      '{2'd0, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd1},  // R1 re-arm clears
      '{2'd2, AA, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd3, 2'd3, 4'd1},  // R1 record gone
      '{2'd2, AA, 1'b1, 1'b0, 2'd2, 16'h0F0F, 2'd1, 2'd2, 4'd8},  // R8 upgrade present
      '{2'd2, BB, 1'b1, 1'b0, 2'd0, 16'h2222, 2'd3, 2'd2, 4'd7}   // R7 nothing armed
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alloc_vld = 1'b0;
   logic [BLK_W-1:0]  alloc_blk = '0;
   logic              alloc_excl = 1'b0;
   logic              vic_vld = 1'b0;
   logic [TAG_W-1:0]  vic_tag = '0;
   logic [SET_W-1:0]  vic_set = '0;
   logic              vic_dirty = 1'b0;
   logic              vic_writable = 1'b0;
   logic [DATA_W-1:0] vic_data = '0;
   logic              rsp_vld = 1'b0;
   logic [1:0]        rsp_kind = 2'd0;
   logic [BLK_W-1:0]  rsp_blk = '0;
   logic              rsp_blk_present = 1'b0;
   logic [DATA_W-1:0] rsp_data = '0;
   logic              fill_vld;
   logic [1:0]        fill_kind;
   logic [BLK_W-1:0]  fill_blk;
   logic [DATA_W-1:0] fill_data;
   logic              reissue_vld;
   logic [BLK_W-1:0]  reissue_blk;
   logic              err_vld;
   logic [1:0]        err_code;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   mshr_upg_track uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_blk(alloc_blk), .alloc_excl(alloc_excl),
      .vic_vld(vic_vld), .vic_tag(vic_tag), .vic_set(vic_set),
      .vic_dirty(vic_dirty), .vic_writable(vic_writable), .vic_data(vic_data),
      .rsp_vld(rsp_vld), .rsp_kind(rsp_kind), .rsp_blk(rsp_blk),
      .rsp_blk_present(rsp_blk_present), .rsp_data(rsp_data),
      .fill_vld(fill_vld), .fill_kind(fill_kind), .fill_blk(fill_blk), .fill_data(fill_data),
      .reissue_vld(reissue_vld), .reissue_blk(reissue_blk),
      .err_vld(err_vld), .err_code(err_code)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      case (v.op)
         2'd0: begin
            alloc_vld  = 1'b1;
            alloc_blk  = v.addr[ADDR_W-1:OFFS_W];
            alloc_excl = v.f1;
         end
         2'd1: begin
            vic_vld      = 1'b1;
            vic_tag      = v.addr[ADDR_W-1:SET_W+OFFS_W];
            vic_set      = v.addr[SET_W+OFFS_W-1:OFFS_W];
            vic_dirty    = v.f1;
            vic_writable = v.f2;
            vic_data     = {8{v.seed}};
         end
         default: begin
            rsp_vld         = 1'b1;
            rsp_kind        = v.kind;
            rsp_blk         = v.addr[ADDR_W-1:OFFS_W];
            rsp_blk_present = v.f1;
            rsp_data        = {8{v.seed}};
         end
      endcase
   endtask

   task automatic idle_inputs();
      alloc_vld = 1'b0;
      vic_vld   = 1'b0;
      rsp_vld   = 1'b0;
   endtask

   // inputs were set at a falling edge; the result is registered at the next rising edge
   task automatic step();
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic expect_out(input vec_t v, input string req);
      logic [2:0] act;
      logic [2:0] exp;
      act = {fill_vld, reissue_vld, err_vld};
      case (v.eout)
         2'd1:    exp = 3'b100;
         2'd2:    exp = 3'b010;
         2'd3:    exp = 3'b001;
         default: exp = 3'b000;
      endcase
      check(act == exp, req, "strobes {fill,reissue,err}", DATA_W'(act), DATA_W'(exp));
      if (v.eout == 2'd1 && fill_vld) begin
         check(fill_kind == v.ecode, req, "fill kind", DATA_W'(fill_kind), DATA_W'(v.ecode));
         check(fill_blk == v.addr[ADDR_W-1:OFFS_W], req, "fill block",
               DATA_W'(fill_blk), DATA_W'(v.addr[ADDR_W-1:OFFS_W]));
      end
      if (v.eout == 2'd2 && reissue_vld) begin
         check(reissue_blk == v.addr[ADDR_W-1:OFFS_W], req, "reissue block",
               DATA_W'(reissue_blk), DATA_W'(v.addr[ADDR_W-1:OFFS_W]));
      end
      if (v.eout == 2'd3 && err_vld) begin
         check(err_code == v.ecode, req, "error code", DATA_W'(err_code), DATA_W'(v.ecode));
      end
   endtask

   // fill data expectations computed from the requirements for the table rows
   function automatic logic [15:0] fill_seed(input int i);
      case (i)
         4:       return 16'hA5C3;  // R5 saved victim data
         10:      return 16'h7E01;  // R4 exclusive-read data
         14:      return 16'h5A5A;  // R8 read data
         20:      return 16'h0F0F;  // R8 upgrade with block present
         default: return 16'h0000;
      endcase
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      vec_t v;
      vec_t w;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({fill_vld, reissue_vld, err_vld} == 3'b000, "R1", "strobes in reset",
            DATA_W'({fill_vld, reissue_vld, err_vld}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check({fill_vld, reissue_vld, err_vld} == 3'b000, "R1", "strobes after reset",
            DATA_W'({fill_vld, reissue_vld, err_vld}), '0);

      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = $sformatf("R%0d(vec %0d)", VECS[i].req, i);
         apply(VECS[i]);
         step();
         expect_out(VECS[i], tag);
         if (VECS[i].eout == 2'd1) begin
            check(fill_data == {8{fill_seed(i)}}, tag, "fill data",
                  fill_data, {8{fill_seed(i)}});
         end
      end

      // R10: allocation beats a same-cycle response
      v = '{2'd0, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd10};
      w = '{2'd2, AA, 1'b1, 1'b0, 2'd0, 16'h9999, 2'd0, 2'd0, 4'd10};
      apply(v); apply(w);
      step();
      expect_out(v, "R10 alloc+rsp");
      w = '{2'd2, AA, 1'b1, 1'b0, 2'd0, 16'h2468, 2'd1, 2'd0, 4'd10};
      apply(w);
      step();
      expect_out(w, "R10 entry armed");
      check(fill_data == {8{16'h2468}}, "R10", "fill data", fill_data, {8{16'h2468}});
      // R11: strobe lasts one cycle
      @(negedge clk);
      check({fill_vld, reissue_vld, err_vld} == 3'b000, "R11", "strobe cleared",
            DATA_W'({fill_vld, reissue_vld, err_vld}), '0);

      // R10: response beats a same-cycle victim notice, which is dropped
      v = '{2'd0, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd0, 2'd0, 4'd10};
      apply(v);
      step();
      v = '{2'd1, AA, 1'b0, 1'b0, 2'd0, 16'h7777, 2'd0, 2'd0, 4'd10};
      w = '{2'd2, AA, 1'b0, 1'b0, 2'd2, 16'h0000, 2'd3, 2'd3, 4'd10};
      apply(v); apply(w);
      step();
      expect_out(w, "R10 rsp+vic");
      apply(w);
      step();
      expect_out(w, "R10 victim dropped");
      w = '{2'd2, AA, 1'b1, 1'b0, 2'd0, 16'h0000, 2'd1, 2'd0, 4'd8};
      apply(w);
      step();
      expect_out(w, "R8 release");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule